// File: doc/BRIEF.md
# Programmable Logic Slice

This block is a small run-time configurable logic element. It holds two 16-entry truth tables. Each table reads as a 4-input function, and a fifth input can merge the two tables into one 5-input function. Either table can also act as a 16x1 memory with a clocked write and an immediate read, or as a 16-bit shift register with an addressable tap. Each table output drives a storage element. By configuration, that element behaves as an edge-triggered flip-flop or as a transparent latch. Its set/reset acts at the clock edge or at once, and its enable and set/reset inputs can each be inverted.

All configuration, truth tables included, enters serially through one data pin while the configuration enable is high. The design that contains the slice streams a 47-bit word into it, then drives the logic inputs and reads the combinational and registered outputs.

Top module: `logic_slice`

## Requirements
- R1: A synchronous active-high `rst` clears every table, every configuration bit and both storage elements, so after reset `comb_out` and `reg_out` are both 2'b00.
- R2: While `cfg_en` is high, each clock shifts the 47-bit configuration vector left by one and places `cfg_din` in bit 0. Bits [15:0] are table A, bits [31:16] are table B, bits [38:32] are the control field of half A, bits [45:39] are the control field of half B, and bit 46 enables F5 merging. Within each 7-bit control field: [6:5] mode (00 logic, 01 memory, 10 shift, 11 logic), [4] latch select, [3] synchronous set/reset, [2] invert enable, [1] invert set/reset, [0] value loaded by set/reset.
- R3: In logic mode, `comb_out[0]` equals table A bit `in_a` and `comb_out[1]` equals table B bit `in_b`, where index bit 3 is the most significant.
- R4: When F5 merging is enabled, table B is indexed by `in_a`, `comb_out[0]` is table A's bit, `comb_out[1]` is table A's bit when `in_x5` is 0 and table B's bit when `in_x5` is 1, and `in_b` has no effect.
- R5: In memory mode, a clock with `we[i]` high writes `wdata[i]` into the addressed table bit, and a read returns the stored bit with no clock delay.
- R6: In shift mode, each clock with `we[i]` high moves the table up by one bit and puts `wdata[i]` in bit 0. The output is the bit addressed by the index inputs.
- R7: In logic mode, `we` has no effect on the table contents.
- R8: In flip-flop mode, `reg_out[i]` takes `comb_out[i]` at a clock edge where the effective enable is high, and it holds otherwise.
- R9: In latch mode, `reg_out[i]` follows `comb_out[i]` without waiting for a clock while the effective enable is high, and it holds the last value once the enable drops.
- R10: With synchronous set/reset, an active set/reset loads the configured value at the next clock edge. With asynchronous set/reset, the value appears at once and persists after release.
- R11: The invert bits flip the sense of the `ce` and `sr` pins.
- R12: While `cfg_en` is high, `reg_out` keeps its value, and the storage elements ignore `ce`, `sr` and `d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| in_a | input | 4 | Index inputs of table A (also table B in F5 mode) |
| in_b | input | 4 | Index inputs of table B |
| in_x5 | input | 1 | Fifth input selecting between the tables |
| we | input | 2 | Per-table write/shift enable |
| wdata | input | 2 | Per-table write/shift data |
| ce | input | 2 | Per-storage-element enable |
| sr | input | 2 | Per-storage-element set/reset |
| comb_out | output | 2 | Combinational outputs |
| reg_out | output | 2 | Storage element outputs |

## Verification
A corrupted table bit appears on `comb_out` the moment its index is applied, so the bench sweeps every index of random tables and places any fault at a single entry. A shift chain off by one position misplaces all of the control fields. This shows up as the wrong mode or storage behaviour on the first write or edge after loading. Faults in storage control show up on `reg_out` either at the first edge or within the same half cycle. For that reason, latch and asynchronous cases are sampled before any edge, and synchronous cases are sampled one edge later.

// File: rtl/logic_slice_pkg.sv
`timescale 1ns/1ps
package logic_slice_pkg;

    typedef enum logic [1:0] {
        LM_LOGIC = 2'b00,
        LM_MEM   = 2'b01,
        LM_SHIFT = 2'b10,
        LM_RSVD  = 2'b11
    } lut_mode_e;

    typedef struct packed {
        lut_mode_e mode;
        logic      latch;
        logic      sync_sr;
        logic      ce_inv;
        logic      sr_inv;
        logic      sr_val;
    } half_ctrl_t;

    typedef struct packed {
        logic            f5_en;
        half_ctrl_t [1:0] half;
    } slice_ctrl_t;

endpackage

// File: rtl/logic_slice_lut.sv
`timescale 1ns/1ps
module logic_slice_lut
    import logic_slice_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             scan_in,
    output logic             scan_out,
    input  lut_mode_e        mode,
    input  logic [IDX_W-1:0] idx,
    input  logic             we,
    input  logic             wdata,
    output logic             y
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] tt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tt <= '0;
        end else if (cfg_en) begin
            tt <= {tt[DEPTH-2:0], scan_in};
        end else if (we && mode == LM_MEM) begin
            tt[idx] <= wdata;
        end else if (we && mode == LM_SHIFT) begin
            tt <= {tt[DEPTH-2:0], wdata};
        end
    end

    assign y        = tt[idx];
    assign scan_out = tt[DEPTH-1];

    // R5: memory write lands at the addressed bit
    a_r5_mem_write: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && we && mode == LM_MEM) |=> tt[$past(idx)] == $past(wdata));

    // R6: shift moves contents up and inserts data at bit 0
    a_r6_shift: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && we && mode == LM_SHIFT) |=>
            (tt[0] == $past(wdata)) && (tt[DEPTH-1:1] == $past(tt[DEPTH-2:0])));

    // R7: logic mode tables are unaffected by write enable
    a_r7_logic_stable: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && (mode == LM_LOGIC || mode == LM_RSVD)) |=> $stable(tt));
endmodule

// File: rtl/logic_slice_store.sv
`timescale 1ns/1ps
module logic_slice_store
    import logic_slice_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_en,
    input  half_ctrl_t ctl,
    input  logic       ce_in,
    input  logic       sr_in,
    input  logic       d,
    output logic       q
);
    logic ce_eff;
    logic sr_eff;
    logic q_reg;

    assign ce_eff = ce_in ^ ctl.ce_inv;
    assign sr_eff = sr_in ^ ctl.sr_inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_reg <= 1'b0;
        end else if (!cfg_en) begin
            if (sr_eff) begin
                q_reg <= ctl.sr_val;
            end else if (ce_eff) begin
                q_reg <= d;
            end
        end
    end

    always_comb begin
        if (cfg_en) begin
            q = q_reg;
        end else if (!ctl.sync_sr && sr_eff) begin
            q = ctl.sr_val;
        end else if (ctl.latch && ce_eff) begin
            q = d;
        end else begin
            q = q_reg;
        end
    end

    // R12: storage holds while configuration is shifting
    a_r12_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable(q_reg));

    // R10: an active set/reset loads the configured value at the edge
    a_r10_sr_load: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && sr_eff) |=> q_reg == $past(ctl.sr_val));

    // R8: enabled capture with no set/reset takes d
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !sr_eff && ce_eff) |=> q_reg == $past(d));
endmodule

// File: rtl/logic_slice.sv
`timescale 1ns/1ps
module logic_slice
    import logic_slice_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [IDX_W-1:0] in_a,
    input  logic [IDX_W-1:0] in_b,
    input  logic             in_x5,
    input  logic [1:0]       we,
    input  logic [1:0]       wdata,
    input  logic [1:0]       ce,
    input  logic [1:0]       sr,
    output logic [1:0]       comb_out,
    output logic [1:0]       reg_out
);
    localparam int HALVES = 2;
    localparam int CTRL_W = $bits(slice_ctrl_t);

    slice_ctrl_t      ctrl_q;
    logic [HALVES:0]  chain;
    logic [1:0]       lut_y;
    logic [IDX_W-1:0] idx [HALVES];

    assign chain[0] = cfg_din;
    assign idx[0]   = in_a;
    assign idx[1]   = ctrl_q.f5_en ? in_a : in_b;

    generate
        for (genvar g = 0; g < HALVES; g++) begin : g_half
            logic scan_o;

            logic_slice_lut #(.IDX_W(IDX_W)) lut_i (
                .clk      (clk),
                .rst      (rst),
                .cfg_en   (cfg_en),
                .scan_in  (chain[g]),
                .scan_out (scan_o),
                .mode     (ctrl_q.half[g].mode),
                .idx      (idx[g]),
                .we       (we[g]),
                .wdata    (wdata[g]),
                .y        (lut_y[g])
            );
            assign chain[g+1] = scan_o;

            logic_slice_store store_i (
                .clk    (clk),
                .rst    (rst),
                .cfg_en (cfg_en),
                .ctl    (ctrl_q.half[g]),
                .ce_in  (ce[g]),
                .sr_in  (sr[g]),
                .d      (comb_out[g]),
                .q      (reg_out[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_en) begin
            ctrl_q <= slice_ctrl_t'({ctrl_q[CTRL_W-2:0], chain[HALVES]});
        end
    end

    assign comb_out[0] = lut_y[0];
    assign comb_out[1] = ctrl_q.f5_en ? (in_x5 ? lut_y[1] : lut_y[0]) : lut_y[1];

    // R2: control field shifts left with the table chain tail at bit 0
    a_r2_ctrl_shift: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> ctrl_q[CTRL_W-1:1] == $past(ctrl_q[CTRL_W-2:0]));

    // R4: in merged mode the fifth input set to 0 selects table A
    always_comb begin
        if (!rst && ctrl_q.f5_en && !in_x5) begin
            a_r4_f5_low: assert (comb_out[1] == comb_out[0]);
        end
    end
endmodule

// File: tb/logic_slice_tb.sv
`timescale 1ns/1ps
module logic_slice_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] in_a = '0;
    logic [3:0] in_b = '0;
    logic       in_x5 = 1'b0;
    logic [1:0] we = '0;
    logic [1:0] wdata = '0;
    logic [1:0] ce = '0;
    logic [1:0] sr = '0;
    logic [1:0] comb_out;
    logic [1:0] reg_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    logic_slice dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .in_a(in_a), .in_b(in_b), .in_x5(in_x5), .we(we), .wdata(wdata),
        .ce(ce), .sr(sr), .comb_out(comb_out), .reg_out(reg_out)
    );

    // control field: {mode[1:0], latch, sync_sr, ce_inv, sr_inv, sr_val}
    localparam logic [6:0] C_FF     = 7'b00_0_1_0_0_0;
    localparam logic [6:0] C_LATCH  = 7'b00_1_1_0_0_0;
    localparam logic [6:0] C_MEM    = 7'b01_0_1_0_0_0;
    localparam logic [6:0] C_SHIFT  = 7'b10_0_1_0_0_0;
    localparam logic [6:0] C_SSET   = 7'b00_0_1_0_0_1;
    localparam logic [6:0] C_ASET   = 7'b00_0_0_0_0_1;
    localparam logic [6:0] C_INV    = 7'b00_0_1_1_1_0;

    function automatic logic [46:0] mk(input logic f5, input logic [6:0] cb,
        input logic [6:0] ca, input logic [15:0] tb, input logic [15:0] ta);
        return {f5, cb, ca, tb, ta};
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_en = 1'b0; we = '0; ce = '0; sr = '0;
        in_a = '0; in_b = '0; in_x5 = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_cfg(input logic [46:0] w);
        @(negedge clk);
        for (int i = 46; i >= 0; i--) begin
            cfg_en = 1'b1;
            cfg_din = w[i];
            @(negedge clk);
        end
        cfg_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 comb", comb_out, 2'b00);
        chk("R1 reg", reg_out, 2'b00);
    endtask

    task automatic t_logic();
        for (int n = 0; n < 3; n++) begin
            logic [15:0] ta, tb;
            ta = 16'($urandom);
            tb = 16'($urandom);
            do_reset();
            load_cfg(mk(1'b0, C_FF, C_FF, tb, ta));
            for (int i = 0; i < 16; i++) begin
                in_a = 4'(i);
                in_b = 4'(15 - i);
                #1;
                chk("R3 R2 logic", comb_out, {tb[15 - i], ta[i]});
            end
        end
    endtask

    task automatic t_f5();
        for (int n = 0; n < 2; n++) begin
            logic [15:0] ta, tb;
            ta = 16'($urandom);
            tb = 16'($urandom);
            do_reset();
            load_cfg(mk(1'b1, C_FF, C_FF, tb, ta));
            for (int x = 0; x < 2; x++) begin
                for (int i = 0; i < 16; i++) begin
                    in_x5 = x[0];
                    in_a = 4'(i);
                    in_b = ~4'(i);
                    #1;
                    chk("R4 f5", comb_out, {(x == 1) ? tb[i] : ta[i], ta[i]});
                end
            end
        end
    endtask

    task automatic t_mem();
        logic [15:0] pat, r2;
        pat = 16'($urandom);
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_MEM, 16'h0, ~pat));
        for (int i = 0; i < 16; i++) begin
            we = 2'b01; wdata = {1'b0, pat[i]}; in_a = 4'(i);
            @(negedge clk);
        end
        we = '0;
        for (int i = 0; i < 16; i++) begin
            in_a = 4'(i);
            #1;
            chk("R5 mem read", {1'b0, comb_out[0]}, {1'b0, pat[i]});
        end
        // R7: write enable in logic mode leaves the table alone
        r2 = 16'($urandom);
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_FF, 16'h0, r2));
        for (int i = 0; i < 16; i++) begin
            we = 2'b01; wdata = {1'b0, ~r2[i]}; in_a = 4'(i);
            @(negedge clk);
        end
        we = '0;
        for (int i = 0; i < 16; i++) begin
            in_a = 4'(i);
            #1;
            chk("R7 no write", {1'b0, comb_out[0]}, {1'b0, r2[i]});
        end
    endtask

    task automatic t_shift();
        logic [15:0] exp_t, src;
        exp_t = 16'($urandom);
        src = 16'($urandom);
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_SHIFT, 16'h0, exp_t));
        for (int k = 0; k < 16; k++) begin
            we = 2'b01; wdata = {1'b0, src[k]};
            @(negedge clk);
            exp_t = {exp_t[14:0], src[k]};
            if (k == 4 || k == 15) begin
                we = '0;
                for (int i = 0; i < 16; i++) begin
                    in_a = 4'(i);
                    #1;
                    chk("R6 shift tap", {1'b0, comb_out[0]}, {1'b0, exp_t[i]});
                end
                @(negedge clk);
            end
        end
        we = '0;
    endtask

    task automatic t_ff();
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_FF, 16'h0, 16'h0020));
        in_a = 4'd5; ce = 2'b01;
        #1;
        chk("R8 no change before edge", reg_out, 2'b00);
        @(negedge clk);
        chk("R8 capture", reg_out, 2'b01);
        ce = 2'b00; in_a = 4'd0;
        @(negedge clk);
        chk("R8 hold", reg_out, 2'b01);
        ce = 2'b01;
        @(negedge clk);
        chk("R8 recapture", reg_out, 2'b00);
    endtask

    task automatic t_latch();
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_LATCH, 16'h0, 16'h0020));
        ce = 2'b01; in_a = 4'd5;
        #1;
        chk("R9 transparent high", reg_out, 2'b01);
        in_a = 4'd0;
        #1;
        chk("R9 transparent low", reg_out, 2'b00);
        in_a = 4'd5;
        @(negedge clk);
        ce = 2'b00; in_a = 4'd0;
        #1;
        chk("R9 closed hold", reg_out, 2'b01);
    endtask

    task automatic t_sr();
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_SSET, 16'h0, 16'h0));
        sr = 2'b01;
        #1;
        chk("R10 sync waits", reg_out, 2'b00);
        @(negedge clk);
        chk("R10 sync set", reg_out, 2'b01);
        sr = 2'b00;
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_ASET, 16'h0, 16'h0));
        sr = 2'b01;
        #1;
        chk("R10 async set", reg_out, 2'b01);
        @(negedge clk);
        sr = 2'b00;
        #1;
        chk("R10 async persists", reg_out, 2'b01);
    endtask

    task automatic t_inv();
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_INV, 16'h0, 16'h0020));
        in_a = 4'd5; ce = 2'b00; sr = 2'b01;
        @(negedge clk);
        chk("R11 inverted enable", reg_out, 2'b01);
        sr = 2'b00;
        @(negedge clk);
        chk("R11 inverted set/reset", reg_out, 2'b00);
    endtask

    task automatic t_hold();
        logic [46:0] w;
        logic ok;
        do_reset();
        load_cfg(mk(1'b0, C_FF, C_FF, 16'h0, 16'h0020));
        in_a = 4'd5; ce = 2'b01;
        @(negedge clk);
        chk("R12 setup", reg_out, 2'b01);
        w = mk(1'b0, C_FF, C_FF, 16'h0, 16'h0);
        ok = 1'b1;
        for (int i = 46; i >= 0; i--) begin
            cfg_en = 1'b1; cfg_din = w[i];
            @(negedge clk);
            if (reg_out[0] !== 1'b1) ok = 1'b0;
        end
        cfg_en = 1'b0;
        chk("R12 hold during load", {1'b0, ok}, 2'b01);
        @(negedge clk);
        chk("R12 resumes after load", reg_out, 2'b00);
        ce = '0;
    endtask

    initial begin
        t_reset();
        t_logic();
        t_f5();
        t_mem();
        t_shift();
        t_ff();
        t_latch();
        t_sr();
        t_inv();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule